// File: doc/BRIEF.md
# Mask-Driven Bit Field Unit

This unit moves a bit field into or out of a byte, where the field is given by the set bits of a mask rather than by a start offset and a width. In a load, the field is pulled out of a source byte and returned right-justified, so software sees it as a small integer. In a store, the low-order bits of a register value are placed into the masked positions of a destination byte, and the bits outside the mask keep their old values.

The mask does not encode a shift amount. The unit finds the shift itself by counting trailing zeros in the mask, which gives the index of the lowest set bit. A start strobe takes in the operands. The result is registered and a valid pulse marks it one clock later. Fetching the destination byte, writing it back and decoding the operation are left to the surrounding datapath.

Top module: `mbf_unit`

## Requirements
- R1: While rst_ni is low, result_o is 0 and valid_o is 0.
- R2: valid_o is 1 in the cycle after a clock edge that samples start_i high, and 0 after an edge that samples start_i low.
- R3: When op_i is 0 (load), result_o holds the mask-selected bits of mem_i. They are shifted down by the index of the lowest set mask bit, and every bit above the field is 0.
- R4: When op_i is 1 (store), each mem_i bit whose mask bit is 1 is replaced by a register bit, and each bit whose mask bit is 0 keeps its mem_i value.
- R5: In a store, mask bit k+t takes reg_i bit k, where t is the lowest set mask index. reg_i bits at or above the field width have no effect.
- R6: An all-zero mask gives 0 for a load, and gives mem_i unchanged for a store.
- R7: A non-contiguous mask raises no error. A load returns (mem_i AND mask) shifted right by t. A store returns (mem_i AND NOT mask) OR ((reg_i shifted left by t) AND mask).
- R8: result_o keeps its value through every cycle in which start_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Operand strobe |
| op_i | input | 1 | 0 = load, 1 = store |
| mask_i | input | DATA_W | Field mask |
| mem_i | input | DATA_W | Load source or store destination byte |
| reg_i | input | DATA_W | Register value for store |
| result_o | output | DATA_W | Registered result |
| valid_o | output | 1 | One-cycle result strobe |

## Verification
The bench builds the unit with the default DATA_W of 8. At this width every mask edge case is within reach: fields that touch bit 0 and bit 7, a full-width mask, an empty mask, and masks with gaps. Stores use register values with set bits above the field width, so any leak of upper register bits shows up in the result. Each result is followed by an idle cycle with changed inputs, to check that the valid pulse drops and the result holds.

// File: rtl/mbf_pkg.sv
package mbf_pkg;
  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_STORE = 1'b1
  } mbf_op_e;
endpackage

// File: rtl/mbf_tzc.sv
module mbf_tzc #(
  parameter int DATA_W = 8,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] mask_i,
  output logic [SH_W-1:0]   tz_o,
  output logic              empty_o
);
  // scan down so the lowest set bit wins
  always_comb begin
    tz_o = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (mask_i[i]) tz_o = SH_W'(i);
    end
  end

  assign empty_o = ~|mask_i;

  // R7: shift amount points at a set bit with nothing set below it
  always_comb begin
    if (!empty_o) begin
      a_r7_tz_lowest: assert (mask_i[tz_o] &&
        ((mask_i & ((DATA_W'(1) << tz_o) - DATA_W'(1))) == '0));
    end
  end
endmodule

// File: rtl/mbf_extract.sv
module mbf_extract #(
  parameter int DATA_W = 8,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [SH_W-1:0]   tz_i,
  output logic [DATA_W-1:0] field_o
);
  logic [DATA_W-1:0] sel;

  assign sel     = src_i & mask_i;
  assign field_o = sel >> tz_i;
endmodule

// File: rtl/mbf_insert.sv
module mbf_insert #(
  parameter int DATA_W = 8,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] val_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [SH_W-1:0]   tz_i,
  output logic [DATA_W-1:0] merged_o
);
  logic [DATA_W-1:0] placed;

  assign placed   = (val_i << tz_i) & mask_i;
  assign merged_o = (dst_i & ~mask_i) | placed;
endmodule

// File: rtl/mbf_unit.sv
module mbf_unit
  import mbf_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              op_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] mem_i,
  input  logic [DATA_W-1:0] reg_i,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o
);
  logic [SH_W-1:0]   tz;
  logic              empty;
  logic [DATA_W-1:0] ld_val, st_val, nxt;
  mbf_op_e           op;

  assign op = mbf_op_e'(op_i);

  mbf_tzc #(.DATA_W(DATA_W)) u_tzc (
    .mask_i (mask_i),
    .tz_o   (tz),
    .empty_o(empty)
  );

  mbf_extract #(.DATA_W(DATA_W)) u_ext (
    .src_i  (mem_i),
    .mask_i (mask_i),
    .tz_i   (tz),
    .field_o(ld_val)
  );

  mbf_insert #(.DATA_W(DATA_W)) u_ins (
    .dst_i   (mem_i),
    .val_i   (reg_i),
    .mask_i  (mask_i),
    .tz_i    (tz),
    .merged_o(st_val)
  );

  // empty mask: load yields 0, store passes the destination
  always_comb begin
    if (op == OP_STORE) nxt = empty ? mem_i : st_val;
    else                nxt = empty ? '0    : ld_val;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= start_i;
      if (start_i) result_o <= nxt;
    end
  end

  a_r2_valid_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);
  a_r2_valid_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o);
  a_r8_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(result_o));
  a_r3_load_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == 1'b0) |=> (result_o & ~($past(mask_i) >> $past(tz))) == '0);
  a_r4_store_keeps_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == 1'b1) |=> ((result_o ^ $past(mem_i)) & ~$past(mask_i)) == '0);
  a_r6_empty_load_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == 1'b0 && mask_i == '0) |=> result_o == '0);
endmodule

// File: tb/mbf_unit_tb_top.sv
`timescale 1ns/1ps
module mbf_unit_tb_top;
  localparam int W = 8;
  localparam int NV = 14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, op = 1'b0;
  logic [W-1:0] mask = '0, mem = '0, regv = '0;
  logic [W-1:0] result;
  logic valid;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  mbf_unit #(.DATA_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .mask_i(mask), .mem_i(mem), .reg_i(regv),
    .result_o(result), .valid_o(valid)
  );

  // {op, mask, mem, reg, expected}
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 8'h3C, 8'hB4, 8'h00, 8'h0D}, // R3 mid field
    {1'b0, 8'hF0, 8'hA5, 8'hFF, 8'h0A}, // R3 top nibble
    {1'b0, 8'h01, 8'hFF, 8'h00, 8'h01}, // R3 bit 0
    {1'b0, 8'h80, 8'h80, 8'h00, 8'h01}, // R3 bit 7
    {1'b0, 8'hFF, 8'h5A, 8'h00, 8'h5A}, // R3 full width
    {1'b1, 8'h3C, 8'hFF, 8'h05, 8'hD7}, // R4 mid field
    {1'b1, 8'h0F, 8'hA0, 8'hF9, 8'hA9}, // R5 upper reg bits ignored
    {1'b1, 8'hC0, 8'h00, 8'hFE, 8'h80}, // R5 top field
    {1'b1, 8'hFF, 8'h12, 8'h34, 8'h34}, // R4 full width
    {1'b0, 8'h00, 8'hFF, 8'hFF, 8'h00}, // R6 empty load
    {1'b1, 8'h00, 8'h6B, 8'hFF, 8'h6B}, // R6 empty store
    {1'b0, 8'h24, 8'hFF, 8'h00, 8'h09}, // R7 gapped load
    {1'b1, 8'h24, 8'h00, 8'hFF, 8'h24}, // R7 gapped store
    {1'b1, 8'h24, 8'h00, 8'h01, 8'h04}  // R7 gapped store, low reg
  };

  function automatic string tag(input int idx);
    if (idx >= 11) return "R7";
    if (idx >= 9)  return "R6";
    if (idx == 6 || idx == 7) return "R5";
    return (idx >= 5) ? "R4" : "R3";
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 result", result, 8'h00);
    check("R1 valid", {7'd0, valid}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 idle valid", {7'd0, valid}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [W-1:0] exp_v;
      {op, mask, mem, regv, exp_v} = VEC[i];
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R2 valid", {7'd0, valid}, 8'h01);
      check(tag(i), result, exp_v);
      mask = ~mask; mem = ~mem; regv = ~regv; op = ~op;
      @(negedge clk);
      check("R2 drop", {7'd0, valid}, 8'h00);
      check("R8 hold", result, exp_v);
    end

    // R2: back-to-back starts keep valid high
    op = 1'b0; mask = 8'h0E; mem = 8'h0A; start = 1'b1;
    @(negedge clk);
    mask = 8'h03; mem = 8'h02;
    @(negedge clk);
    check("R2 back-to-back valid", {7'd0, valid}, 8'h01);
    check("R3 second load", result, 8'h02);
    start = 1'b0;
    @(negedge clk);

    // R1: async reset clears a held result
    rst_n = 1'b0;
    #1;
    check("R1 async result", result, 8'h00);
    check("R1 async valid", {7'd0, valid}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule